// File: doc/BRIEF.md
# PTP Time Counter with Fractional Rate Trim

This block keeps a free-running precision time value, made of a 32-bit seconds count and a 30-bit nanoseconds count, and presents it continuously to timestamping logic. Every clock cycle counts as one tick. On each tick the nanoseconds advance by a programmable nominal period. When they pass one second they wrap, and the seconds count goes up by one in the same cycle.

Software reaches the block through a narrow 16-bit register port with a write enable, an address and a combinational read-data path. Through this port software can stage a new time value and commit it in a single cycle. It can also freeze a copy of the live time into read registers, so the halves it reads back all belong to one instant. A signed fractional-nanosecond trim corrects the rate: a 32-bit accumulator gains the trim on every tick, and each carry out of it lengthens or shortens that tick by one nanosecond. Coarse offsets are applied by software as a snapshot, an add and a load.

Top module: `ptp_trim_clock`

## Requirements
- R1: While reset is low, `now_ns` and `now_sec` are zero. The period register (address 1) reads 15, and the committed trim is zero.
- R2: With no trim carry, `now_ns` grows by the period register value on each clock. The period register is written and read back at address 1.
- R3: When nanoseconds plus the step reach 1,000,000,000 or more, the next `now_ns` is that sum minus 1,000,000,000, and `now_sec` goes up by one in the same cycle.
- R4: Addresses 4 and 5 stage nanoseconds bits 15:0 and 29:16 (the latter in data bits 13:0), and addresses 6 and 7 stage seconds bits 15:0 and 31:16. Writing address 0 with data bit 0 set makes the time equal the staged value in the next cycle.
- R5: A load wins over the tick in the same cycle, so the loaded value has no period added. The load also clears the fraction accumulator.
- R6: Writing address 0 with data bit 2 set captures the time as it stood just before that clock edge. The capture is read at addresses 8 (ns 15:0), 9 (ns 29:16 in bits 13:0), 10 (sec 15:0) and 11 (sec 31:16).
- R7: If a single write to address 0 sets both bit 0 and bit 2, the capture holds the pre-load time.
- R8: Address 2 stages trim bits 15:0 and reads back the staged value. In a write to address 3, bit 15 commits the trim as {data bits 13:0, staged low half}, and bit 14 selects the direction, 1 meaning faster. Address 3 reads {0, direction, committed trim bits 29:16}. In faster mode, a tick on which the accumulator carries steps the period plus 1.
- R9: In slower mode (bit 14 = 0), a tick on which the accumulator carries steps the period minus 1.
- R10: A write to address 3 with bit 15 clear changes neither the rate nor the value read back from address 3.
- R11: The capture registers keep their value until the next capture command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the addressed register (combinational) |
| now_sec | output | 32 | Live seconds |
| now_ns | output | 30 | Live nanoseconds |

## Verification
Two functions can share one clock edge. The first pair is the load command and the snapshot command: the bench sets both bits in a single command write and then expects the pre-load time, known exactly from the preceding ticks, in the capture registers, while the live time equals the staged value. The second pair is the load and the tick: the bench judges it by the absence of any period added to the loaded value. It also times the first trim carry after a load, which shows that the accumulator was cleared.

// File: rtl/ptp_trim_pkg.sv
// Shared widths, constants and register addresses for the PTP trim clock.
// Assumes one tick per clock cycle.
package ptp_trim_pkg;
    localparam int NS_W      = 30;
    localparam int SEC_W     = 32;
    localparam int FRAC_W    = 32;
    localparam int REG_W     = 16;
    localparam int ADDR_W    = 4;
    localparam int NS_HI_W   = NS_W - REG_W;       // 14
    localparam int TRIM_HI_W = 14;
    localparam int STEP_W    = REG_W + 1;
    localparam logic [NS_W:0] NS_WRAP = 31'd1_000_000_000;

    typedef enum logic [ADDR_W-1:0] {
        A_CMD       = 4'd0,
        A_PERIOD    = 4'd1,
        A_TRIM_LO   = 4'd2,
        A_TRIM_HI   = 4'd3,
        A_SET_NS_LO = 4'd4,
        A_SET_NS_HI = 4'd5,
        A_SET_S_LO  = 4'd6,
        A_SET_S_HI  = 4'd7,
        A_SNP_NS_LO = 4'd8,
        A_SNP_NS_HI = 4'd9,
        A_SNP_S_LO  = 4'd10,
        A_SNP_S_HI  = 4'd11
    } reg_addr_e;

    localparam int CMD_LOAD_BIT = 0;
    localparam int CMD_SNAP_BIT = 2;
    localparam int TRIM_LD_BIT  = 15;
    localparam int TRIM_DIR_BIT = 14;
endpackage

// File: rtl/ptp_trim_regs.sv
// Register file of the PTP trim clock. It decodes writes, holds the staged
// time, the period, the trim and the capture registers, and drives the
// combinational read mux. The command strobes act on the edge of the write.
// Assumes single-cycle write pulses from the management port.
module ptp_trim_regs
    import ptp_trim_pkg::*;
#(
    parameter int PERIOD_RST = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [NS_W-1:0]   now_ns,
    input  logic [SEC_W-1:0]  now_sec,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              load_pulse,
    output logic              snap_pulse,
    output logic [NS_W-1:0]   set_ns,
    output logic [SEC_W-1:0]  set_sec,
    output logic [REG_W-1:0]  period,
    output logic [FRAC_W-1:0] trim,
    output logic              trim_faster,
    output logic [NS_W-1:0]   snap_ns,
    output logic [SEC_W-1:0]  snap_sec
);
    logic [REG_W-1:0]   set_ns_lo, set_s_lo, set_s_hi, trim_lo_stage;
    logic [NS_HI_W-1:0] set_ns_hi;
    logic               cmd_wr;

    // Command strobes, decoded from the write cycle itself
    always_comb begin
        cmd_wr     = reg_we && (reg_addr == A_CMD);
        load_pulse = cmd_wr && reg_wdata[CMD_LOAD_BIT];
        snap_pulse = cmd_wr && reg_wdata[CMD_SNAP_BIT];
    end

    assign set_ns  = {set_ns_hi, set_ns_lo};
    assign set_sec = {set_s_hi, set_s_lo};

    // Staged time halves and nominal period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_ns_lo <= '0;
            set_ns_hi <= '0;
            set_s_lo  <= '0;
            set_s_hi  <= '0;
            period    <= REG_W'(PERIOD_RST);
        end else if (reg_we) begin
            case (reg_addr)
                A_SET_NS_LO: set_ns_lo <= reg_wdata;
                A_SET_NS_HI: set_ns_hi <= reg_wdata[NS_HI_W-1:0];
                A_SET_S_LO:  set_s_lo  <= reg_wdata;
                A_SET_S_HI:  set_s_hi  <= reg_wdata;
                A_PERIOD:    period    <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Trim staging; the high write with its strobe commits all 32 bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trim_lo_stage <= '0;
            trim          <= '0;
            trim_faster   <= 1'b0;
        end else if (reg_we) begin
            if (reg_addr == A_TRIM_LO)
                trim_lo_stage <= reg_wdata;
            if (reg_addr == A_TRIM_HI && reg_wdata[TRIM_LD_BIT]) begin
                trim <= {{(FRAC_W-REG_W-TRIM_HI_W){1'b0}},
                         reg_wdata[TRIM_HI_W-1:0], trim_lo_stage};
                trim_faster <= reg_wdata[TRIM_DIR_BIT];
            end
        end
    end

    // Capture of the pre-edge live time on a snapshot command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_ns  <= '0;
            snap_sec <= '0;
        end else if (snap_pulse) begin
            snap_ns  <= now_ns;
            snap_sec <= now_sec;
        end
    end

    // Read mux
    always_comb begin
        case (reg_addr)
            A_PERIOD:    reg_rdata = period;
            A_TRIM_LO:   reg_rdata = trim_lo_stage;
            A_TRIM_HI:   reg_rdata = {1'b0, trim_faster,
                                      trim[REG_W+TRIM_HI_W-1:REG_W]};
            A_SET_NS_LO: reg_rdata = set_ns_lo;
            A_SET_NS_HI: reg_rdata = {{(REG_W-NS_HI_W){1'b0}}, set_ns_hi};
            A_SET_S_LO:  reg_rdata = set_s_lo;
            A_SET_S_HI:  reg_rdata = set_s_hi;
            A_SNP_NS_LO: reg_rdata = snap_ns[REG_W-1:0];
            A_SNP_NS_HI: reg_rdata = {{(REG_W-NS_HI_W){1'b0}}, snap_ns[NS_W-1:REG_W]};
            A_SNP_S_LO:  reg_rdata = snap_sec[REG_W-1:0];
            A_SNP_S_HI:  reg_rdata = snap_sec[SEC_W-1:REG_W];
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ptp_trim_frac.sv
// Fractional accumulator. Each tick it adds the trim and turns a carry out
// into a one-nanosecond lengthening or shortening of the nominal step.
// Assumes period >= 1 when the slower direction is used.
module ptp_trim_frac
    import ptp_trim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [FRAC_W-1:0] trim,
    input  logic              faster,
    input  logic [REG_W-1:0]  period,
    output logic [STEP_W-1:0] step
);
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   acc_sum;
    logic [STEP_W-1:0] base;

    // Next accumulator value and the resulting step
    always_comb begin
        acc_sum = {1'b0, acc} + {1'b0, trim};
        base    = {1'b0, period};
        if (!acc_sum[FRAC_W])
            step = base;
        else if (faster)
            step = base + STEP_W'(1);
        else
            step = base - STEP_W'(1);
    end

    // Accumulator register; a time load clears it
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            acc <= '0;
        else
            acc <= acc_sum[FRAC_W-1:0];
    end
endmodule

// File: rtl/ptp_trim_counter.sv
// Seconds and nanoseconds counter. A load replaces the time; otherwise the
// step is added and the nanoseconds wrap at one second.
// Assumes step is far below one second.
module ptp_trim_counter
    import ptp_trim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [NS_W-1:0]   set_ns,
    input  logic [SEC_W-1:0]  set_sec,
    input  logic [STEP_W-1:0] step,
    output logic [NS_W-1:0]   now_ns,
    output logic [SEC_W-1:0]  now_sec
);
    logic [NS_W:0] ns_sum, ns_wrapped;
    logic          wrap;

    // Sum and one-second wrap detection
    always_comb begin
        ns_sum     = {1'b0, now_ns} + {{(NS_W+1-STEP_W){1'b0}}, step};
        wrap       = (ns_sum >= NS_WRAP);
        ns_wrapped = wrap ? (ns_sum - NS_WRAP) : ns_sum;
    end

    // Time register; load has priority over the tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now_ns  <= '0;
            now_sec <= '0;
        end else if (load) begin
            now_ns  <= set_ns;
            now_sec <= set_sec;
        end else begin
            now_ns  <= ns_wrapped[NS_W-1:0];
            now_sec <= now_sec + SEC_W'(wrap);
        end
    end
endmodule

// File: rtl/ptp_trim_clock.sv
// Top of the PTP time counter with fractional rate trim. It joins the
// register file, the fraction accumulator and the time counter.
// Assumes the clock runs at the nominal tick rate.
module ptp_trim_clock
    import ptp_trim_pkg::*;
#(
    parameter int PERIOD_RST = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [SEC_W-1:0]  now_sec,
    output logic [NS_W-1:0]   now_ns
);
    logic              load_pulse, snap_pulse, trim_faster;
    logic [NS_W-1:0]   set_ns, snap_ns;
    logic [SEC_W-1:0]  set_sec, snap_sec;
    logic [REG_W-1:0]  period;
    logic [FRAC_W-1:0] trim;
    logic [STEP_W-1:0] step;

    ptp_trim_regs #(.PERIOD_RST(PERIOD_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .now_ns(now_ns), .now_sec(now_sec),
        .reg_rdata(reg_rdata), .load_pulse(load_pulse), .snap_pulse(snap_pulse),
        .set_ns(set_ns), .set_sec(set_sec), .period(period), .trim(trim),
        .trim_faster(trim_faster), .snap_ns(snap_ns), .snap_sec(snap_sec)
    );

    ptp_trim_frac u_frac (
        .clk(clk), .rst_n(rst_n), .clear(load_pulse), .trim(trim),
        .faster(trim_faster), .period(period), .step(step)
    );

    ptp_trim_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load_pulse), .set_ns(set_ns),
        .set_sec(set_sec), .step(step), .now_ns(now_ns), .now_sec(now_sec)
    );
endmodule

// File: rtl/ptp_trim_clock_chk.sv
// Property checker for the PTP trim clock, attached by bind.
module ptp_trim_clock_chk
    import ptp_trim_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              load_pulse,
    input logic              snap_pulse,
    input logic [NS_W-1:0]   set_ns,
    input logic [SEC_W-1:0]  set_sec,
    input logic [NS_W-1:0]   snap_ns,
    input logic [SEC_W-1:0]  snap_sec,
    input logic [REG_W-1:0]  period,
    input logic [STEP_W-1:0] step,
    input logic [NS_W-1:0]   now_ns,
    input logic [SEC_W-1:0]  now_sec
);
    // R3
    ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_pulse && ({1'b0, now_ns} < NS_WRAP)) |=> ({1'b0, now_ns} < NS_WRAP));

    // R3
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_pulse |=> (now_sec == $past(now_sec)) || (now_sec == $past(now_sec) + 32'd1));

    // R4
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> (now_ns == $past(set_ns)) && (now_sec == $past(set_sec)));

    // R6
    snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap_pulse |=> (snap_ns == $past(now_ns)) && (snap_sec == $past(now_sec)));

    // R11
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_pulse |=> $stable(snap_ns) && $stable(snap_sec));

    // R8
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period != '0) |-> (step + STEP_W'(1) >= {1'b0, period}) &&
                           (step <= {1'b0, period} + STEP_W'(1)));
endmodule

bind ptp_trim_clock ptp_trim_clock_chk u_chk (
    .clk(clk), .rst_n(rst_n), .load_pulse(load_pulse), .snap_pulse(snap_pulse),
    .set_ns(set_ns), .set_sec(set_sec), .snap_ns(snap_ns), .snap_sec(snap_sec),
    .period(period), .step(step), .now_ns(now_ns), .now_sec(now_sec)
);

// File: tb/tb_ptp_trim_clock.sv
// Scoreboard bench: driver tasks push expected values, a monitor pops and
// compares them shortly after each falling edge.
module tb_ptp_trim_clock;
    localparam logic [3:0] CMD = 4'd0, PER = 4'd1, TLO = 4'd2, THI = 4'd3;
    localparam logic [3:0] SNL = 4'd4, SNH = 4'd5, SSL = 4'd6, SSH = 4'd7;
    localparam logic [3:0] CNL = 4'd8, CNH = 4'd9, CSL = 4'd10, CSH = 4'd11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [31:0] now_sec;
    logic [29:0] now_ns;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int          kind;   // 0 read data, 1 nanoseconds, 2 seconds
        logic [31:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sb[$];

    ptp_trim_clock dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .now_sec(now_sec), .now_ns(now_ns)
    );

    always #10 clk = ~clk;

    task automatic push(int kind, logic [31:0] exp, string tag);
        sb_item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    endtask

    task automatic chk_time(logic [29:0] ns, logic [31:0] sec, string tag);
        @(negedge clk); reg_we = 1'b0;
        push(1, {2'b0, ns}, tag);
        push(2, sec, tag);
    endtask

    task automatic chk_rd(logic [3:0] a, logic [15:0] exp, string tag);
        @(negedge clk); reg_we = 1'b0; reg_addr = a;
        push(0, {16'h0, exp}, tag);
    endtask

    task automatic set_time(logic [29:0] ns, logic [31:0] sec);
        wr(SNL, ns[15:0]);
        wr(SNH, {2'b0, ns[29:16]});
        wr(SSL, sec[15:0]);
        wr(SSH, sec[31:16]);
    endtask

    // Monitor: compare queued expectations against the outputs
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                sb_item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0:       act = {16'h0, reg_rdata};
                    1:       act = {2'b0, now_ns};
                    default: act = now_sec;
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d actual=%0d expected=%0d",
                             it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Driver
    initial begin
        // R1: reset state
        chk_time(30'd0, 32'd0, "R1");
        chk_time(30'd0, 32'd0, "R1");
        chk_rd(PER, 16'd15, "R1");
        @(negedge clk); rst_n = 1'b1;
        // R2: nominal stepping
        chk_time(30'd15, 32'd0, "R2");
        chk_time(30'd30, 32'd0, "R2");
        // R4 load, R3 rollover
        set_time(30'd999_999_990, 32'h0001_0002);
        wr(CMD, 16'h0001);
        chk_time(30'd999_999_990, 32'h0001_0002, "R4");
        chk_time(30'd5, 32'h0001_0003, "R3");
        // R5 load priority with a new period, R3 and R2
        wr(PER, 16'd100);
        wr(CMD, 16'h0001);
        chk_time(30'd999_999_990, 32'h0001_0002, "R5");
        chk_time(30'd90, 32'h0001_0003, "R3");
        chk_time(30'd190, 32'h0001_0003, "R2");
        chk_rd(PER, 16'd100, "R2");
        // R6 snapshot of the pre-edge time (390), R11 hold
        wr(CMD, 16'h0004);
        idle(); idle(); idle();
        chk_rd(CNL, 16'd390, "R6");
        chk_rd(CNH, 16'd0, "R6");
        chk_rd(CSL, 16'h0003, "R6");
        chk_rd(CSH, 16'h0001, "R6");
        idle(); idle();
        chk_rd(CNL, 16'd390, "R11");
        // R7 snapshot and load in one command write
        set_time(30'd1000, 32'd3);
        wr(CMD, 16'h0001);
        chk_time(30'd1000, 32'd3, "R4");
        set_time(30'd500, 32'd7);
        wr(CMD, 16'h0005);
        chk_time(30'd500, 32'd7, "R7");
        chk_rd(CNL, 16'd1500, "R7");
        chk_rd(CSL, 16'd3, "R7");
        // R8 faster trim of 1/8 ns per tick, R5 accumulator clear
        wr(TLO, 16'h0000);
        wr(THI, 16'hE000);
        set_time(30'd0, 32'd0);
        wr(CMD, 16'h0001);
        chk_time(30'd0, 32'd0, "R5");
        for (int i = 0; i < 6; i++) idle();
        chk_time(30'd700, 32'd0, "R8");
        chk_time(30'd801, 32'd0, "R8");
        chk_rd(THI, 16'h6000, "R8");
        // R9 slower trim
        wr(THI, 16'hA000);
        set_time(30'd0, 32'd0);
        wr(CMD, 16'h0001);
        chk_time(30'd0, 32'd0, "R9");
        for (int i = 0; i < 6; i++) idle();
        chk_time(30'd700, 32'd0, "R9");
        chk_time(30'd799, 32'd0, "R9");
        // R10 high write without strobe is not committed
        wr(TLO, 16'h1234);
        wr(THI, 16'h4000);
        chk_rd(THI, 16'h2000, "R10");
        chk_rd(TLO, 16'h1234, "R10");
        set_time(30'd0, 32'd0);
        wr(CMD, 16'h0001);
        chk_time(30'd0, 32'd0, "R10");
        for (int i = 0; i < 6; i++) idle();
        chk_time(30'd700, 32'd0, "R10");
        chk_time(30'd799, 32'd0, "R10");
        idle(); idle();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule